// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a down-counting periodic timer that sits behind a small 32-bit register port. Software sets a reload value, picks whether the count advances on every core clock cycle or only in cycles where a slower reference enable is high, and turns the counter on. On each such tick the counter steps down by one. When it moves from 1 to 0, the block sets a sticky expiry flag and, if interrupts are enabled, raises a one-cycle interrupt pulse. On the following tick the counter reloads, so the period is the reload value plus one tick.

The register port is a single-beat request/response channel. A request is accepted in the cycle its valid is high; the block never stalls, so there is no ready signal. Exactly one cycle later the response valid is high for one cycle, with the read data and an error bit. The response cannot be back-pressured, so the requester must take it in that cycle. A request flagged as unprivileged is refused with an error and changes nothing, not even the read-to-clear flag.

Register map (byte offsets, 32-bit words only): 0x0 control/status, 0x4 reload, 0x8 current count, 0xC calibration.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-count registers all read 0, and the interrupt and response valid outputs are low.
- R2: A write to control/status (0x0) changes only bit 0 (run enable), bit 1 (interrupt enable) and bit 2 (clock select, 1 = core clock, 0 = reference enable). Bit 16 (expiry flag) is not writable, and all other bits read 0.
- R3: The reload register (0x4) stores the low 24 bits of the written word and reads them back zero-extended.
- R4: While running, the count drops by one per tick and loads the reload value on the tick after it reaches 0. A tick is every core cycle when bit 2 is 1, and each cycle with ref_tick_en high when bit 2 is 0.
- R5: The 1-to-0 step sets the expiry flag, bit 16. If bit 1 is set, the same step also drives irq_pulse high for exactly one cycle.
- R6: A privileged read of control/status returns the flag as it was and then clears it.
- R7: A privileged write of any value to the current-count register (0x8) sets the count to 0 and clears the flag. The next tick then loads the reload value.
- R8: If the count expires while the reload value is 0, counting halts and the run enable bit still reads 1. Writing the enable bit from 0 to 1 resumes counting.
- R9: The calibration register (0xC) always reads 10000. Writes to it are ignored. Any other offset, including offsets that are not word-aligned, reads 0, and writes to it have no effect.
- R10: An access with req_user high gets rsp_err high and rsp_rdata 0, and leaves every register, including the flag, unchanged.
- R11: rsp_valid is high exactly in the cycle after a cycle with req_valid high. Read data reflects register state before the edge that accepts the request.
- R12: With the run enable bit at 0, the count holds its value. Setting the enable again continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_en | input | 1 | One-cycle reference tick enable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Request is unprivileged |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access refused as unprivileged |
| irq_pulse | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
Every response is due in the cycle after its request edge. The bench drives each request half a cycle before that edge and reads the response at the next falling edge. A count read therefore returns the value from before the accepting edge, and the expected count sequences are worked out edge by edge from the control write that starts the counter. The flag and irq_pulse are registered on the same edge as the 1-to-0 step, so the bench counts irq highs at each falling edge over a fixed window and derives the expected total from the reload period. Reference-mode ticks are single falling-edge-to-falling-edge pulses on ref_tick_en, each followed by a count read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W     = 32;
  localparam int OFF_CTRL   = 'h0;
  localparam int OFF_RELOAD = 'h4;
  localparam int OFF_CUR    = 'h8;
  localparam int OFF_CALIB  = 'hC;
  localparam int EN_BIT     = 0;
  localparam int IE_BIT     = 1;
  localparam int SRC_BIT    = 2;
  localparam int FLAG_BIT   = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CUR,
    SEL_CALIB
  } reg_sel_e;
endpackage

// File: rtl/tick_access_decode.sv
module tick_access_decode
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          sel,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              deny
);
  always_comb begin
    if (req_addr == ADDR_W'(OFF_CTRL))        sel = SEL_CTRL;
    else if (req_addr == ADDR_W'(OFF_RELOAD)) sel = SEL_RELOAD;
    else if (req_addr == ADDR_W'(OFF_CUR))    sel = SEL_CUR;
    else if (req_addr == ADDR_W'(OFF_CALIB))  sel = SEL_CALIB;
    else                                      sel = SEL_NONE;
  end

  assign deny  = req_valid && req_user;
  assign wr_ok = req_valid && !req_user && req_write;
  assign rd_ok = req_valid && !req_user && !req_write;
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             halted_q;
  logic             advance;
  logic             reload_zero;

  assign reload_zero = (reload == '0);
  assign advance     = step && !halted_q && !clear;
  assign expire      = advance && (count_q == ONE);
  assign count       = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      if (clear)
        count_q <= '0;
      else if (advance)
        count_q <= (count_q == '0) ? reload : count_q - ONE;

      if ((clear || expire) && reload_zero)
        halted_q <= 1'b1;
      else if (restart)
        halted_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_read_mux.sv
module tick_read_mux
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int CALIB_VAL = 10000
) (
  input  reg_sel_e            sel,
  input  logic                run_en,
  input  logic                irq_en,
  input  logic                src_core,
  input  logic                flag,
  input  logic [CNT_W-1:0]    reload,
  input  logic [CNT_W-1:0]    count,
  output logic [DATA_W-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: begin
        rdata[EN_BIT]   = run_en;
        rdata[IE_BIT]   = irq_en;
        rdata[SRC_BIT]  = src_core;
        rdata[FLAG_BIT] = flag;
      end
      SEL_RELOAD: rdata = DATA_W'(reload);
      SEL_CUR:    rdata = DATA_W'(count);
      SEL_CALIB:  rdata = DATA_W'(CALIB_VAL);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 8,
  parameter int CALIB_VAL = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              irq_pulse
);
  reg_sel_e          sel;
  logic              wr_ok, rd_ok, deny;
  logic              en_q, ie_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt;
  logic              expire;
  logic              step, clear_cnt, restart;
  logic              ctrl_wr, ctrl_rd;
  logic [DATA_W-1:0] rd_mux;
  logic              rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              wdata_unused;

  assign wdata_unused = ^req_wdata[DATA_W-1:CNT_W];

  tick_access_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_user  (req_user),
    .req_addr  (req_addr),
    .sel       (sel),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .deny      (deny)
  );

  assign ctrl_wr   = wr_ok && (sel == SEL_CTRL);
  assign ctrl_rd   = rd_ok && (sel == SEL_CTRL);
  assign clear_cnt = wr_ok && (sel == SEL_CUR);
  assign restart   = ctrl_wr && req_wdata[EN_BIT] && !en_q;
  assign step      = en_q && (src_q || ref_tick_en);

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .clear   (clear_cnt),
    .restart (restart),
    .reload  (reload_q),
    .count   (cnt),
    .expire  (expire)
  );

  tick_read_mux #(.CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)) u_mux (
    .sel      (sel),
    .run_en   (en_q),
    .irq_en   (ie_q),
    .src_core (src_q),
    .flag     (flag_q),
    .reload   (reload_q),
    .count    (cnt),
    .rdata    (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= req_wdata[EN_BIT];
        ie_q  <= req_wdata[IE_BIT];
        src_q <= req_wdata[SRC_BIT];
      end
      if (wr_ok && (sel == SEL_RELOAD))
        reload_q <= req_wdata[CNT_W-1:0];
      if (expire)
        flag_q <= 1'b1;
      else if (ctrl_rd || clear_cnt)
        flag_q <= 1'b0;
      irq_q <= expire && ie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_err_q   <= deny;
      rsp_rdata_q <= rd_ok ? rd_mux : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign irq_pulse = irq_q;
endmodule

// File: rtl/periodic_tick_timer_chk.sv
module periodic_tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_user,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              irq_pulse,
  input logic              flag,
  input logic              run_en,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  count
);
  logic cur_wr;
  assign cur_wr = req_valid && req_write && !req_user && (req_addr == ADDR_W'(8));

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10
  user_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user) |=> rsp_err);
  // R10
  user_keeps_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user) |=> $stable(reload));
  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R5
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag);
  // R12
  stopped_count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cur_wr) |=> $stable(count));
endmodule

bind periodic_tick_timer periodic_tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_user  (req_user),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .irq_pulse (irq_pulse),
  .flag      (flag_q),
  .run_en    (en_q),
  .reload    (reload_q),
  .count     (cnt)
);

// File: tb/periodic_tick_timer_bench.sv
`timescale 1ns/1ps
module periodic_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        irq_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  periodic_tick_timer u_periodic_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick_en(ref_tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_user(req_user),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_pulse(irq_pulse)
  );

  typedef struct packed {
    logic        wr;
    logic        usr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_err;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 8'h04, 32'h12345678, 32'h0,        1'b0},
    '{1'b0, 1'b0, 8'h04, 32'h0,        32'h00345678, 1'b0},
    '{1'b1, 1'b0, 8'h00, 32'hFFFFFFFA, 32'h0,        1'b0},
    '{1'b0, 1'b0, 8'h00, 32'h0,        32'h00000002, 1'b0},
    '{1'b0, 1'b0, 8'h0C, 32'h0,        32'd10000,    1'b0},
    '{1'b1, 1'b0, 8'h0C, 32'h1,        32'h0,        1'b0},
    '{1'b0, 1'b0, 8'h0C, 32'h0,        32'd10000,    1'b0},
    '{1'b0, 1'b0, 8'h10, 32'h0,        32'h0,        1'b0},
    '{1'b1, 1'b0, 8'h10, 32'h0000FFFF, 32'h0,        1'b0},
    '{1'b0, 1'b0, 8'h06, 32'h0,        32'h0,        1'b0},
    '{1'b0, 1'b1, 8'h04, 32'h0,        32'h0,        1'b1},
    '{1'b1, 1'b1, 8'h04, 32'h0,        32'h0,        1'b1},
    '{1'b0, 1'b0, 8'h04, 32'h0,        32'h00345678, 1'b0},
    '{1'b1, 1'b1, 8'h00, 32'h7,        32'h0,        1'b1},
    '{1'b0, 1'b0, 8'h00, 32'h0,        32'h00000002, 1'b0},
    '{1'b1, 1'b0, 8'h00, 32'h0,        32'h0,        1'b0},
    '{1'b0, 1'b0, 8'h00, 32'h0,        32'h0,        1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the response.
  task automatic acc(input logic w, input logic u, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er, output logic vl);
    req_write = w; req_user = u; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er, vl;
    acc(1'b1, 1'b0, a, d, rd, er, vl);
  endtask

  task automatic rd_exp(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er, vl;
    acc(1'b0, 1'b0, a, 32'h0, rd, er, vl);
    chk(tag, rd, exp);
    chk("R11 rsp_valid", {31'b0, vl}, 32'h1);
  endtask

  task automatic ref_pulse();
    ref_tick_en = 1'b1;
    @(negedge clk);
    ref_tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd; logic er, vl;
    int irq_cnt; logic prev_irq; int dbl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq_pulse}, 32'h0);
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_exp("R1 ctrl reset", 8'h00, 32'h0);
    rd_exp("R1 reload reset", 8'h04, 32'h0);
    rd_exp("R1 count reset", 8'h08, 32'h0);

    // Vector table: R2 R3 R9 R10 register behaviour with the counter off
    for (int i = 0; i < NVEC; i++) begin
      acc(VEC[i].wr, VEC[i].usr, VEC[i].addr, VEC[i].wdata, rd, er, vl);
      chk($sformatf("R2/R3/R9/R10 vec %0d rdata", i), rd, VEC[i].exp_rd);
      chk($sformatf("R10 vec %0d err", i), {31'b0, er}, {31'b0, VEC[i].exp_err});
      chk($sformatf("R11 vec %0d valid", i), {31'b0, vl}, 32'h1);
    end

    // R4 core-clock counting, R7 clear, R6 read-to-clear, R10 flag kept
    wr(8'h04, 32'd5);
    wr(8'h08, 32'hDEAD);
    wr(8'h00, 32'h5);
    begin
      int exp_seq [8] = '{0, 5, 4, 3, 2, 1, 0, 5};
      for (int k = 0; k < 8; k++) rd_exp("R4 core count", 8'h08, exp_seq[k]);
    end
    acc(1'b0, 1'b1, 8'h00, 32'h0, rd, er, vl);
    chk("R10 user ctrl read err", {31'b0, er}, 32'h1);
    chk("R10 user ctrl read data", rd, 32'h0);
    rd_exp("R10 R5 flag survives user read", 8'h00, 32'h00010005);
    rd_exp("R6 flag cleared by read", 8'h00, 32'h00000005);
    wr(8'h00, 32'h0);
    rd_exp("R12 count frozen", 8'h08, 32'h0);
    repeat (5) @(negedge clk);
    rd_exp("R12 count still frozen", 8'h08, 32'h0);
    rd_exp("R5 flag with enable off", 8'h00, 32'h00010000);

    // R4 reference-enable counting, R12 resume
    wr(8'h00, 32'h1);
    rd_exp("R4 ref idle", 8'h08, 32'h0);
    rd_exp("R4 ref idle again", 8'h08, 32'h0);
    ref_pulse();
    rd_exp("R4 ref tick reload", 8'h08, 32'd5);
    ref_pulse();
    rd_exp("R4 ref tick decrement", 8'h08, 32'd4);

    // R5 interrupt pulses: reload 2 gives one every 3 cycles
    wr(8'h00, 32'h0);
    wr(8'h04, 32'd2);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h7);
    irq_cnt = 0; prev_irq = 1'b0; dbl = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (irq_pulse) irq_cnt++;
      if (irq_pulse && prev_irq) dbl++;
      prev_irq = irq_pulse;
    end
    chk("R5 irq count", irq_cnt, 32'd10);
    chk("R5 irq one cycle", dbl, 32'd0);
    wr(8'h00, 32'h5);
    irq_cnt = 0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (irq_pulse) irq_cnt++;
    end
    chk("R5 no irq when disabled", irq_cnt, 32'd0);

    // R7 write to current count
    wr(8'h08, 32'h00ABCDEF);
    rd_exp("R7 flag cleared by count write", 8'h00, 32'h00000005);
    rd_exp("R7 reload after clear", 8'h08, 32'd2);

    // R8 zero reload halts with enable still set
    wr(8'h00, 32'h0);
    wr(8'h04, 32'd3);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h5);
    wr(8'h04, 32'h0);
    begin
      int exp_seq [6] = '{3, 2, 1, 0, 0, 0};
      for (int k = 0; k < 6; k++) rd_exp("R8 count to halt", 8'h08, exp_seq[k]);
    end
    rd_exp("R8 enable kept, flag set", 8'h00, 32'h00010005);
    rd_exp("R8 no further expiry", 8'h00, 32'h00000005);
    wr(8'h04, 32'd4);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h5);
    rd_exp("R8 resume pre-tick", 8'h08, 32'h0);
    rd_exp("R8 resume reload", 8'h08, 32'd4);

    finish_run();
  end
endmodule